// File: doc/BRIEF.md
# MDIO Multi-PHY Auto-Polling Engine

This block looks after sixteen external Ethernet PHYs through a single management clock and data pair, with no host involvement. When reset is released with polling enabled, it first loads the local auto-negotiation advertisement word into every PHY. It then tells each PHY to restart auto-negotiation. After that it enters an endless sweep. In each sweep it reads every PHY's basic status and link-partner ability registers and turns the results into four per-port status vectors: link good, 100 Mb/s, full duplex and pause usable.

Port n talks to PHY address 8+n. A polling-enable strap is sampled during reset. When the strap is low, the engine stays silent and reports every port as up, 100 Mb/s, full duplex and pause capable, so that downstream MAC logic can run on fixed settings. The management data line leaves the block as three signals (input, output value and output enable), and the tristate pad sits outside the block.

Top module: `mdio_poller`

## Requirements
- R1: Port n (0..15) is addressed as PHY 8+n, and within each phase ports are visited in ascending order.
- R2: Every frame is 32 ones followed by start bits 01, a 2-bit opcode, 5-bit PHY address and 5-bit register address, all MSB first. The opcode is 01 for write and 10 for read. A write then sends turnaround 10 and the 16 data bits MSB first. The first phase writes register 4 of every PHY with the advertisement input.
- R3: After the advertisement phase, every PHY gets a write of 0x1200 to register 0, which sets auto-negotiation enable (bit 12) and restart (bit 9).
- R4: After the restart phase, the engine loops forever. For each port in turn it reads register 1 and then register 5, and after port 15 it wraps back to port 0.
- R5: In a read frame, the output enable is low from the first turnaround bit to the end of the frame. The PHY's 16 data bits are sampled on MDC rising edges, MSB first.
- R6: A port's link bit equals bit 2 of its register 1 value.
- R7: With c = advertisement AND partner ability, and the link up, the port resolves to 100 full if c[8] is set. Otherwise it is 100 half if c[7] is set, 10 full if c[6] is set, and 10 half in every other case. The speed bit is 1 for 100 Mb/s and the duplex bit is 1 for full.
- R8: The pause bit is 1 only when the resolved mode is full duplex and bit 10 is set in both words. When the link is down, the port's speed, duplex and pause bits are all 0.
- R9: If the strap is high at reset, all four vectors reset to all zeros. If it is low, they reset to all ones, and the engine then never drives MDIO and keeps MDC low.
- R10: MDC is high for MDC_HALF_CYC system clocks and low for MDC_HALF_CYC system clocks while a frame runs, and it stays low between frames.
- R11: A port's vector bits change only when its register 5 read completes. At that point no other port's bits change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poll_en_strap | input | 1 | Polling enable, sampled while reset is held |
| adv_word | input | 16 | Advertisement value written to register 4 |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data from the pad |
| mdio_o | output | 1 | Management data value to drive |
| mdio_oe | output | 1 | Drive enable for the management data pad |
| link_up | output | NPORTS | Per-port link good |
| speed_100 | output | NPORTS | Per-port 100 Mb/s |
| full_duplex | output | NPORTS | Per-port full duplex |
| pause_ok | output | NPORTS | Per-port pause usable |

## Verification
The hardest case to reach from the ports is a PHY whose register values change in the middle of a sweep. In that case the block has already read the new link bit but has not yet folded in the partner ability. The bench's PHY model logs each frame as it ends. It alters one port's registers right after the first sweep, then stops at the exact frame count where only that port's register 1 read has completed. There it confirms that no vector has moved, and after the following register 5 read it confirms that only that port's bits changed.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
  typedef enum logic [1:0] {PH_ADV, PH_ANRST, PH_LINK, PH_PART} phase_e;

  typedef struct packed {
    logic spd;
    logic fdx;
    logic pse;
  } res_t;

  localparam logic [4:0]  REG_CTRL = 5'd0;
  localparam logic [4:0]  REG_STAT = 5'd1;
  localparam logic [4:0]  REG_ADV  = 5'd4;
  localparam logic [4:0]  REG_LPA  = 5'd5;
  localparam logic [15:0] AN_RESTART_WORD = 16'h1200;
  localparam int STAT_LINK_BIT = 2;
  localparam int AB_100F  = 8;
  localparam int AB_100H  = 7;
  localparam int AB_10F   = 6;
  localparam int AB_PAUSE = 10;

  // Frame body after the preamble: start, opcode, phy, reg, turnaround, data.
  function automatic logic [31:0] mk_frame(input logic rd, input logic [4:0] phy,
                                           input logic [4:0] ra, input logic [15:0] wd);
    mk_frame = {2'b01, (rd ? 2'b10 : 2'b01), phy, ra, (rd ? 2'b11 : 2'b10),
                (rd ? 16'h0000 : wd)};
  endfunction

  // Highest common mode wins; pause only with full duplex.
  function automatic res_t resolve(input logic [15:0] adv, input logic [15:0] lp,
                                   input logic up);
    logic [15:0] c;
    res_t r;
    c = adv & lp;
    r = '0;
    if (up) begin
      r.spd = c[AB_100F] | c[AB_100H];
      r.fdx = c[AB_100F] | (!c[AB_100H] & c[AB_10F]);
      r.pse = r.fdx & c[AB_PAUSE];
    end
    return r;
  endfunction
endpackage

// File: rtl/mdp_mdc.sv
module mdp_mdc #(
  parameter int HALF = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic tick_rise,
  output logic tick_fall
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap      = (cnt == CW'(HALF - 1));
  assign tick_rise = en && wrap && !mdc;
  assign tick_fall = en && wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R10: clock parked low whenever no frame is running
  p_mdc_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);
  // R10: a rising MDC edge only comes out of an active frame
  p_rise_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $past(en));
endmodule

// File: rtl/mdp_frame.sv
module mdp_frame (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_rise,
  input  logic        tick_fall,
  input  logic        start,
  input  logic        rd_in,
  input  logic [31:0] body,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data
);
  localparam int PRE_BITS = 32;
  localparam int TOT_BITS = PRE_BITS + 32;
  localparam logic [5:0] TA_POS   = 6'd46;
  localparam logic [5:0] DATA_POS = 6'd48;
  localparam logic [5:0] LAST_POS = 6'(TOT_BITS - 1);

  logic [TOT_BITS-1:0] sr;
  logic [5:0]          bit_q;
  logic                rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr      <= '1;
      bit_q   <= '0;
      rd_q    <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          sr    <= {{PRE_BITS{1'b1}}, body};
          bit_q <= '0;
          rd_q  <= rd_in;
          busy  <= 1'b1;
        end
      end else begin
        if (tick_rise && rd_q && bit_q >= DATA_POS)
          rd_data <= {rd_data[14:0], mdio_i};
        if (tick_fall) begin
          if (bit_q == LAST_POS) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bit_q <= bit_q + 6'd1;
            sr    <= {sr[TOT_BITS-2:0], 1'b1};
          end
        end
      end
    end
  end

  assign mdio_o  = busy ? sr[TOT_BITS-1] : 1'b1;
  assign mdio_oe = busy && !(rd_q && bit_q >= TA_POS);

  // R5: the line is released while read data is being sampled
  p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_rise && busy && rd_q && bit_q >= DATA_POS) |-> !mdio_oe);
  // R2: completion leaves the shifter idle
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R4: a new frame is never requested on top of a running one
  p_start_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/mdp_seq.sv
module mdp_seq
  import mdp_pkg::*;
#(
  parameter int NPORTS   = 16,
  parameter int PHY_BASE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_strap,
  input  logic [15:0]       adv,
  input  logic              done,
  input  logic [15:0]       rd_data,
  output logic              start,
  output logic              rd,
  output logic [31:0]       body,
  output logic              eng_on,
  output logic [NPORTS-1:0] link_v,
  output logic [NPORTS-1:0] spd_v,
  output logic [NPORTS-1:0] fdx_v,
  output logic [NPORTS-1:0] pse_v
);
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  typedef enum logic [1:0] {SQ_OFF, SQ_ISSUE, SQ_WAIT} sq_e;

  sq_e           st;
  phase_e        ph;
  logic [PW-1:0] port;
  logic          link_hold;
  logic          last_port;
  logic [4:0]    phy;
  logic          upd;
  res_t          res;

  assign last_port = (port == PW'(NPORTS - 1));
  assign phy       = 5'(PHY_BASE) + 5'(port);
  assign start     = (st == SQ_ISSUE);
  assign eng_on    = (st != SQ_OFF);
  assign upd       = (st == SQ_WAIT) && done && (ph == PH_PART);
  assign res       = resolve(adv, rd_data, link_hold);

  always_comb begin
    rd = (ph == PH_LINK) || (ph == PH_PART);
    case (ph)
      PH_ADV:   body = mk_frame(1'b0, phy, REG_ADV, adv);
      PH_ANRST: body = mk_frame(1'b0, phy, REG_CTRL, AN_RESTART_WORD);
      PH_LINK:  body = mk_frame(1'b1, phy, REG_STAT, 16'h0000);
      default:  body = mk_frame(1'b1, phy, REG_LPA, 16'h0000);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= poll_strap ? SQ_ISSUE : SQ_OFF;
      ph        <= PH_ADV;
      port      <= '0;
      link_hold <= 1'b0;
      link_v    <= {NPORTS{!poll_strap}};
      spd_v     <= {NPORTS{!poll_strap}};
      fdx_v     <= {NPORTS{!poll_strap}};
      pse_v     <= {NPORTS{!poll_strap}};
    end else begin
      case (st)
        SQ_ISSUE: st <= SQ_WAIT;
        SQ_WAIT: if (done) begin
          st <= SQ_ISSUE;
          case (ph)
            PH_ADV: begin
              port <= last_port ? '0 : port + 1'b1;
              if (last_port) ph <= PH_ANRST;
            end
            PH_ANRST: begin
              port <= last_port ? '0 : port + 1'b1;
              if (last_port) ph <= PH_LINK;
            end
            PH_LINK: begin
              link_hold <= rd_data[STAT_LINK_BIT];
              ph        <= PH_PART;
            end
            default: begin
              link_v[port] <= link_hold;
              spd_v[port]  <= res.spd;
              fdx_v[port]  <= res.fdx;
              pse_v[port]  <= res.pse;
              ph           <= PH_LINK;
              port         <= last_port ? '0 : port + 1'b1;
            end
          endcase
        end
        default: st <= st;
      endcase
    end
  end

  // R11: vectors hold between partner-ability completions
  p_vec_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(link_v) && $stable(spd_v) && $stable(fdx_v) && $stable(pse_v)));
  // R11: one completion moves at most one port's bit
  p_one_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> ($countones(spd_v ^ $past(spd_v)) <= 1 && $countones(link_v ^ $past(link_v)) <= 1));
  // R8: no speed, duplex or pause without link
  p_no_mode_without_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((spd_v | fdx_v | pse_v) & ~link_v) == '0);
  // R8: pause only alongside full duplex
  p_pause_needs_fdx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pse_v & ~fdx_v) == '0);
endmodule

// File: rtl/mdio_poller.sv
module mdio_poller #(
  parameter int NPORTS       = 16,
  parameter int PHY_BASE     = 8,
  parameter int MDC_HALF_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_en_strap,
  input  logic [15:0]       adv_word,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [NPORTS-1:0] link_up,
  output logic [NPORTS-1:0] speed_100,
  output logic [NPORTS-1:0] full_duplex,
  output logic [NPORTS-1:0] pause_ok
);
  logic        tick_rise, tick_fall;
  logic        fr_start, fr_rd, fr_busy, fr_done;
  logic [31:0] fr_body;
  logic [15:0] fr_rdata;
  logic        eng_on;

  mdp_mdc #(.HALF(MDC_HALF_CYC)) u_mdc (
    .clk(clk), .rst_n(rst_n), .en(fr_busy),
    .mdc(mdc), .tick_rise(tick_rise), .tick_fall(tick_fall)
  );

  mdp_frame u_frame (
    .clk(clk), .rst_n(rst_n), .tick_rise(tick_rise), .tick_fall(tick_fall),
    .start(fr_start), .rd_in(fr_rd), .body(fr_body), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(fr_busy), .done(fr_done),
    .rd_data(fr_rdata)
  );

  mdp_seq #(.NPORTS(NPORTS), .PHY_BASE(PHY_BASE)) u_seq (
    .clk(clk), .rst_n(rst_n), .poll_strap(poll_en_strap), .adv(adv_word),
    .done(fr_done), .rd_data(fr_rdata), .start(fr_start), .rd(fr_rd),
    .body(fr_body), .eng_on(eng_on),
    .link_v(link_up), .spd_v(speed_100), .fdx_v(full_duplex), .pse_v(pause_ok)
  );

  // R9: a disabled engine never touches the management pins
  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_on |-> (!mdio_oe && !mdc));
  // R9: a disabled engine keeps every port reported as fully capable
  p_off_all_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_on |-> (&link_up && &speed_100 && &full_duplex && &pause_ok));
endmodule

// File: tb/mdio_poller_tb_top.sv
module mdio_poller_tb_top;
  localparam int NP   = 16;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b1;
  logic [15:0] adv = 16'h05E1;
  logic mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;
  logic [NP-1:0] lnk, spd, fdx, pse;
  int checks = 0, errors = 0;
  bit done_all = 0;

  always #5 clk = ~clk;

  mdio_poller #(.NPORTS(NP), .PHY_BASE(8), .MDC_HALF_CYC(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .poll_en_strap(strap), .adv_word(adv),
    .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .link_up(lnk), .speed_100(spd), .full_duplex(fdx), .pause_ok(pse)
  );

  // ---------------- PHY model and frame log ----------------
  logic [15:0] r1 [NP];
  logic [15:0] r5 [NP];
  int ones = 0, idx = 0, pre_hold = 0, ta_bad = 0, n_log = 0;
  bit in_fr = 0;
  logic [13:0] hdr;
  logic [17:0] tail;
  logic [15:0] rd_val;
  logic [1:0]  lg_op [256];
  logic [1:0]  lg_st [256];
  logic [1:0]  lg_ta [256];
  logic [4:0]  lg_phy [256];
  logic [4:0]  lg_reg [256];
  logic [15:0] lg_dat [256];
  int          lg_pre [256];

  always @(posedge mdc) begin
    if (!in_fr) begin
      if (mdio_oe && mdio_o) ones++;
      else if (mdio_oe && !mdio_o && ones >= 32) begin
        in_fr = 1; idx = 32; hdr = 14'd0; pre_hold = ones;
      end else ones = 0;
    end else begin
      idx++;
      if (idx <= 45) hdr = {hdr[12:0], mdio_o};
      else begin
        if (hdr[11:10] == 2'b10 && mdio_oe) ta_bad++;
        tail = {tail[16:0], mdio_o};
      end
      if (idx == 45) begin
        int p;
        p = int'(hdr[9:5]) - 8;
        if (p < 0 || p >= NP) rd_val = 16'hFFFF;
        else if (hdr[4:0] == 5'd1) rd_val = r1[p];
        else if (hdr[4:0] == 5'd5) rd_val = r5[p];
        else rd_val = 16'hFFFF;
      end
      if (idx == 63) begin
        if (n_log < 256) begin
          lg_st[n_log]  = hdr[13:12];
          lg_op[n_log]  = hdr[11:10];
          lg_phy[n_log] = hdr[9:5];
          lg_reg[n_log] = hdr[4:0];
          lg_ta[n_log]  = tail[17:16];
          lg_dat[n_log] = (hdr[11:10] == 2'b10) ? rd_val : tail[15:0];
          lg_pre[n_log] = pre_hold;
        end
        n_log++;
        in_fr = 0; ones = 0;
      end
    end
  end

  always @(negedge mdc) begin
    if (in_fr && hdr[11:10] == 2'b10 && idx >= 47 && idx <= 62) mdio_i = rd_val[62 - idx];
    else mdio_i = 1'b1;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    rst_n = 1'b0; strap = s;
    repeat (5) @(posedge clk);
    n_log = 0; in_fr = 0; ones = 0; ta_bad = 0;
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic wait_log(input int k);
    int t = 0;
    while (n_log < k && t < 60000) begin @(negedge clk); t++; end
    if (n_log < k) chk("WAIT_LOG", 32'(n_log), 32'(k));
  endtask

  // Independent expectation: {link, speed, duplex, pause}
  function automatic logic [3:0] expect_bits(input int i);
    logic up, s, d, p;
    logic [15:0] c;
    up = r1[i][2];
    c = adv & r5[i];
    s = 0; d = 0; p = 0;
    if (up) begin
      if (c[8]) begin s = 1; d = 1; end
      else if (c[7]) begin s = 1; d = 0; end
      else if (c[6]) begin s = 0; d = 1; end
      p = d && adv[10] && r5[i][10];
    end
    return {up, s, d, p};
  endfunction

  logic [NP-1:0] e_l, e_s, e_d, e_p;
  task automatic build_expect();
    for (int i = 0; i < NP; i++) {e_l[i], e_s[i], e_d[i], e_p[i]} = expect_bits(i);
  endtask

  task automatic set_phys();
    for (int i = 0; i < NP; i++) begin
      r1[i] = (i % 7 == 6) ? 16'h7869 : 16'h786D;
      case (i % 5)
        0: r5[i] = 16'h05E1;
        1: r5[i] = 16'h00A1;
        2: r5[i] = 16'h0441;
        3: r5[i] = 16'h0021;
        default: r5[i] = 16'h0101;
      endcase
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_on();
    do_reset(1'b1);
    @(negedge clk);
    chk("R9 vectors zero with polling on", {lnk, spd}, 32'h0);
    chk("R9 vectors zero with polling on", {fdx, pse}, 32'h0);
    chk("R10 mdc low after reset", 32'(mdc), 32'h0);
  endtask

  task automatic t_mdc_period();
    int hi = 0, lo = 0;
    while (!mdc) @(negedge clk);
    while (mdc) begin hi++; @(negedge clk); end
    while (!mdc) begin lo++; @(negedge clk); end
    chk("R10 mdc high time", 32'(hi), 32'(HALF));
    chk("R10 mdc low time", 32'(lo), 32'(HALF));
  endtask

  task automatic t_init();
    wait_log(32);
    for (int i = 0; i < NP; i++) begin
      chk("R1 adv phy addr", 32'(lg_phy[i]), 32'(8 + i));
      chk("R2 adv frame", {lg_st[i], lg_op[i], lg_ta[i], 3'b0, lg_reg[i], lg_dat[i]},
          {2'b01, 2'b01, 2'b10, 3'b0, 5'd4, adv});
      chk("R2 preamble length", 32'(lg_pre[i]), 32'd32);
      chk("R1 restart phy addr", 32'(lg_phy[16 + i]), 32'(8 + i));
      chk("R3 restart frame", {lg_op[16 + i], lg_ta[16 + i], 7'b0, lg_reg[16 + i], lg_dat[16 + i]},
          {2'b01, 2'b10, 7'b0, 5'd0, 16'h1200});
    end
  endtask

  task automatic t_poll();
    wait_log(64);
    repeat (4 * HALF + 6) @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      chk("R4 status read order", {lg_op[32 + 2*i], 3'b0, lg_phy[32 + 2*i], 3'b0, lg_reg[32 + 2*i]},
          {2'b10, 3'b0, 5'(8 + i), 3'b0, 5'd1});
      chk("R4 partner read order", {lg_op[33 + 2*i], 3'b0, lg_phy[33 + 2*i], 3'b0, lg_reg[33 + 2*i]},
          {2'b10, 3'b0, 5'(8 + i), 3'b0, 5'd5});
    end
    chk("R5 line released in read frames", 32'(ta_bad), 32'h0);
    build_expect();
    chk("R6 link vector", 32'(lnk), 32'(e_l));
    chk("R7 speed vector", 32'(spd), 32'(e_s));
    chk("R7 duplex vector", 32'(fdx), 32'(e_d));
    chk("R8 pause vector", 32'(pse), 32'(e_p));
  endtask

  task automatic t_isolate();
    logic [NP-1:0] o_l, o_s, o_d, o_p;
    o_l = e_l; o_s = e_s; o_d = e_d; o_p = e_p;
    r1[3] = 16'h7869;
    wait_log(65);
    chk("R4 sweep wraps to port 0", {lg_phy[64], 3'b0, lg_reg[64]}, {5'd8, 3'b0, 5'd1});
    wait_log(71);
    repeat (4 * HALF + 6) @(negedge clk);
    chk("R11 no change after status read", {lnk, spd}, {o_l, o_s});
    chk("R11 no change after status read", {fdx, pse}, {o_d, o_p});
    wait_log(72);
    repeat (4 * HALF + 6) @(negedge clk);
    build_expect();
    chk("R8 link down clears port 3", {lnk[3], spd[3], fdx[3], pse[3]}, 4'b0000);
    chk("R11 only port 3 changed", {lnk, spd}, {e_l, e_s});
    chk("R11 only port 3 changed", {fdx, pse}, {e_d, e_p});
    chk("R6 port 3 link follows register", 32'(lnk ^ o_l), 32'h0008);
  endtask

  task automatic t_disabled();
    int bad = 0;
    do_reset(1'b0);
    @(negedge clk);
    chk("R9 vectors all ones with polling off", {lnk, spd}, 32'hFFFF_FFFF);
    chk("R9 vectors all ones with polling off", {fdx, pse}, 32'hFFFF_FFFF);
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (mdc || mdio_oe) bad++;
    end
    chk("R9 no bus activity when off", 32'(bad), 32'h0);
    chk("R9 no frames when off", 32'(n_log), 32'h0);
    chk("R9 vectors stay ones", {lnk & spd & fdx & pse}, 32'(16'hFFFF));
  endtask

  initial begin
    set_phys();
    t_reset_on();
    t_mdc_period();
    t_init();
    t_poll();
    t_isolate();
    t_disabled();
    done_all = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_all) begin
      checks++; errors++;
      $display("FAIL WATCHDOG actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule